// File: doc/BRIEF.md
# Complementary PWM Output Idle-State Controller

This block is the last stage of a four-channel PWM timer, sitting between the PWM reference generators and the pins. Channels 0 to 2 each drive a main pin and a complementary pin. Channel 3 drives only a main pin. While the primary output enable is high, each main pin follows its PWM reference and each complementary pin follows the inverse of that reference. Inside every complementary pair, the turn-on edge of either pin is held back by a programmable dead-time, so the two pins of a pair are never high together.

When the primary output enable drops, every pin moves to its own programmable idle level. A complementary pin takes its idle level on the next clock edge. The main pin of a pair waits out the dead-time before it moves. The channel-3 pin moves on the next edge. The idle levels sit in a 16-bit control word. Writes to that word are accepted only while the two-bit lock level is zero.

Top module: `ocs_out_stage`

## Requirements
- R1: While reset is asserted and after it is released, with the enable low and no write, every pin is low and the control word reads 0x0000.
- R2: In the control word, bit 8 is the ch0 main idle level, bit 9 the ch0 complementary, bit 10 ch1 main, bit 11 ch1 complementary, bit 12 ch2 main, bit 13 ch2 complementary and bit 14 the ch3 main idle level. Bits 0 to 7 and bit 15 always read zero. A written word can be read back from the edge after the write.
- R3: A write changes the control word only when the lock level is 0. With a lock level of 1, 2 or 3, the word and the pins it sets stay unchanged.
- R4: With the enable low, a pair's main pin reaches its idle level D edges after the complementary pin of that pair has changed, where D is the dead-time. The ch3 pin takes its idle level one edge after its input changes.
- R5: With the enable low, every complementary pin shows its idle bit from the edge after that bit (or the enable) changes.
- R6: With the enable high, a falling edge of a pair pin appears one edge after its reference changes. The main pin follows the reference and the complementary pin follows the inverted reference.
- R7: With the enable high, a rising edge of a pair pin appears exactly D edges after the matching falling edge. With D = 0, both pins switch on the same edge.
- R8: With the enable high, from the next edge on, no pair ever has its main pin and its complementary pin high at the same time.
- R9: With the enable high, the ch3 pin follows its reference one edge later, with no dead-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_ref | input | 4 | PWM reference level per channel |
| out_en | input | 1 | Primary output enable |
| lock_lvl | input | 2 | Write-protection level; writes allowed at 0 |
| dead_time | input | 8 | Dead-time in clock cycles |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Control-word write data |
| ch_out | output | 4 | Main pin levels, ch0 to ch3 |
| chn_out | output | 3 | Complementary pin levels, ch0 to ch2 |
| idle_word | output | 16 | Control-word readback |

## Verification
Two of this block's actions can meet on the same edge. When the enable falls, a pair's complementary pin jumps to its idle level straight away, while its main pin is still in the dead-time hold. The bench provokes this by clearing the enable while the references are high and the idle bits put the two pins of each pair in opposite states. It then checks at every edge that the complementary pins move on the first edge, that the main pins hold through edge D, and that they drop on edge D+1. A second overlap occurs when an idle-word write changes a pair's target while the enable is low. That write restarts the dead-time in the same way, and the bench judges the result by counting edges against the dead-time value.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
    localparam int DT_W = 8;

    typedef logic [DT_W-1:0] dt_cnt_t;

    // state of one complementary pair sequencer
    typedef struct packed {
        dt_cnt_t cnt;    // remaining dead-time cycles
        logic    tgt_m;  // last seen main target
        logic    tgt_c;  // last seen complementary target
        logic    main;   // registered main pin
        logic    comp;   // registered complementary pin
    } pair_st_t;
endpackage

// File: rtl/ocs_idle_reg.sv
module ocs_idle_reg #(
    parameter int NUM_CH   = 4,
    parameter int NUM_COMP = 3,
    parameter int WORD_W   = 16,
    parameter int IDLE_LSB = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [1:0]          lock_lvl,
    output logic [NUM_CH-1:0]   idle_m,
    output logic [NUM_COMP-1:0] idle_c,
    output logic [WORD_W-1:0]   rd_word
);
    typedef struct packed {
        logic [NUM_CH-1:0]   m;
        logic [NUM_COMP-1:0] c;
    } idle_t;

    idle_t st_d, st_q;
    logic  wr_ok;
    logic  unused_bits;

    assign unused_bits = ^wr_data;
    assign wr_ok       = wr_en && (lock_lvl == 2'b00);

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            for (int i = 0; i < NUM_CH; i++) begin
                st_d.m[i] = wr_data[IDLE_LSB + 2*i];
            end
            for (int i = 0; i < NUM_COMP; i++) begin
                st_d.c[i] = wr_data[IDLE_LSB + 2*i + 1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            rd_word[IDLE_LSB + 2*i] = st_q.m[i];
        end
        for (int i = 0; i < NUM_COMP; i++) begin
            rd_word[IDLE_LSB + 2*i + 1] = st_q.c[i];
        end
    end

    assign idle_m = st_q.m;
    assign idle_c = st_q.c;
endmodule

// File: rtl/ocs_dt_pair.sv
module ocs_dt_pair
    import ocs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    out_en,
    input  logic    ref_i,
    input  logic    idle_m,
    input  logic    idle_c,
    input  dt_cnt_t dead_time,
    output logic    main_o,
    output logic    comp_o
);
    pair_st_t st_d, st_q;
    logic     tgt_m, tgt_c;
    logic     hold_m, hold_c;
    logic     done;

    always_comb begin
        tgt_m = out_en ? ref_i  : idle_m;
        tgt_c = out_en ? ~ref_i : idle_c;
        // running: falls pass at once, rises wait; idle: comp passes, main waits
        hold_m = out_en ? (st_q.main & tgt_m) : st_q.main;
        hold_c = out_en ? (st_q.comp & tgt_c) : tgt_c;

        st_d = st_q;
        if ({tgt_m, tgt_c} != {st_q.tgt_m, st_q.tgt_c}) begin
            st_d.tgt_m = tgt_m;
            st_d.tgt_c = tgt_c;
            st_d.cnt   = dead_time;
            done       = (dead_time == '0);
        end else begin
            done     = (st_q.cnt <= dt_cnt_t'(1));
            st_d.cnt = done ? '0 : st_q.cnt - 1'b1;
        end

        if (done) begin
            st_d.main = tgt_m;
            st_d.comp = tgt_c;
        end else begin
            st_d.main = hold_m;
            st_d.comp = hold_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_o = st_q.main;
    assign comp_o = st_q.comp;
endmodule

// File: rtl/ocs_single.sv
module ocs_single (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic ref_i,
    input  logic idle_m,
    output logic main_o
);
    logic pin_d, pin_q;

    always_comb pin_d = out_en ? ref_i : idle_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign main_o = pin_q;
endmodule

// File: rtl/ocs_out_stage.sv
module ocs_out_stage #(
    parameter int NUM_CH   = 4,
    parameter int NUM_COMP = 3,
    parameter int WORD_W   = 16,
    parameter int IDLE_LSB = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        pwm_ref,
    input  logic                     out_en,
    input  logic [1:0]               lock_lvl,
    input  logic [ocs_pkg::DT_W-1:0] dead_time,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [NUM_CH-1:0]        ch_out,
    output logic [NUM_COMP-1:0]      chn_out,
    output logic [WORD_W-1:0]        idle_word
);
    logic [NUM_CH-1:0]   idle_m;
    logic [NUM_COMP-1:0] idle_c;

    ocs_idle_reg #(
        .NUM_CH(NUM_CH), .NUM_COMP(NUM_COMP), .WORD_W(WORD_W), .IDLE_LSB(IDLE_LSB)
    ) u_idle (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .lock_lvl(lock_lvl), .idle_m(idle_m), .idle_c(idle_c), .rd_word(idle_word)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i < NUM_COMP) begin : g_pair
            ocs_dt_pair u_pair (
                .clk(clk), .rst_n(rst_n), .out_en(out_en), .ref_i(pwm_ref[i]),
                .idle_m(idle_m[i]), .idle_c(idle_c[i]), .dead_time(dead_time),
                .main_o(ch_out[i]), .comp_o(chn_out[i])
            );
        end else begin : g_single
            ocs_single u_one (
                .clk(clk), .rst_n(rst_n), .out_en(out_en), .ref_i(pwm_ref[i]),
                .idle_m(idle_m[i]), .main_o(ch_out[i])
            );
        end
    end
endmodule

// File: rtl/ocs_out_stage_chk.sv
module ocs_out_stage_chk #(
    parameter int NUM_CH   = 4,
    parameter int NUM_COMP = 3,
    parameter int WORD_W   = 16,
    parameter int IDLE_LSB = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   pwm_ref,
    input logic                out_en,
    input logic [1:0]          lock_lvl,
    input logic                wr_en,
    input logic [NUM_COMP-1:0] chn_out,
    input logic [NUM_CH-1:0]   ch_out,
    input logic [WORD_W-1:0]   idle_word
);
    logic [NUM_COMP-1:0] icomp;
    always_comb begin
        for (int i = 0; i < NUM_COMP; i++) icomp[i] = idle_word[IDLE_LSB + 2*i + 1];
    end

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_lvl != 2'b00) |=> $stable(idle_word));

    p_comp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (chn_out == $past(icomp)));

    p_fall_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> ((ch_out[NUM_COMP-1:0] & ~$past(pwm_ref[NUM_COMP-1:0])) == '0));

    p_fall_comp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> ((chn_out & $past(pwm_ref[NUM_COMP-1:0])) == '0));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> ((ch_out[NUM_COMP-1:0] & chn_out) == '0));

    if (NUM_CH > NUM_COMP) begin : g_single_chk
        p_single_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_en |=> (ch_out[NUM_CH-1] == $past(pwm_ref[NUM_CH-1])));

        p_single_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en |=> (ch_out[NUM_CH-1] == $past(idle_word[IDLE_LSB + 2*(NUM_CH-1)])));
    end
endmodule

bind ocs_out_stage ocs_out_stage_chk #(
    .NUM_CH(NUM_CH), .NUM_COMP(NUM_COMP), .WORD_W(WORD_W), .IDLE_LSB(IDLE_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .out_en(out_en), .lock_lvl(lock_lvl),
    .wr_en(wr_en), .chn_out(chn_out), .ch_out(ch_out), .idle_word(idle_word)
);

// File: tb/ocs_out_stage_test.sv
`timescale 1ns/1ps
module ocs_out_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pwm_ref = '0;
    logic        out_en = 1'b0;
    logic [1:0]  lock_lvl = '0;
    logic [7:0]  dead_time = 8'd3;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  ch_out;
    logic [2:0]  chn_out;
    logic [15:0] idle_word;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ocs_out_stage uut (
        .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .out_en(out_en), .lock_lvl(lock_lvl),
        .dead_time(dead_time), .wr_en(wr_en), .wr_data(wr_data),
        .ch_out(ch_out), .chn_out(chn_out), .idle_word(idle_word)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pins(string tag, logic [3:0] m, logic [2:0] c);
        chk({tag, " main"}, 32'(ch_out), 32'(m));
        chk({tag, " comp"}, 32'(chn_out), 32'(c));
    endtask

    task automatic write_word(logic [1:0] lk, logic [15:0] w);
        @(negedge clk);
        lock_lvl = lk; wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; lock_lvl = 2'b00;
    endtask

    task automatic t_reset;
        step(2);
        pins("R1 in reset", 4'b0000, 3'b000);
        @(negedge clk) rst_n = 1'b1;
        step(2);
        pins("R1 after reset", 4'b0000, 3'b000);
        chk("R1 word", 32'(idle_word), 32'h0);
    endtask

    task automatic t_layout;
        write_word(2'b00, 16'hFFFF);
        chk("R2 reserved bits zero", 32'(idle_word), 32'h7F00);
        write_word(2'b00, 16'h5500);   // all mains idle high, comps idle low
        chk("R2 readback", 32'(idle_word), 32'h5500);
        step(1);
        pins("R4 idle ch3 first edge", 4'b1000, 3'b000);
        step(2);
        pins("R4 idle main held", 4'b1000, 3'b000);
        step(1);
        pins("R4 idle main after dead-time", 4'b1111, 3'b000);
    endtask

    task automatic t_lock;
        for (int lk = 1; lk < 4; lk++) begin
            write_word(2'(lk), 16'h2A00);
            chk("R3 locked word", 32'(idle_word), 32'h5500);
            step(5);
            pins("R3 locked pins", 4'b1111, 3'b000);
        end
        write_word(2'b00, 16'h2A00);   // mains idle low, comps idle high
        chk("R3 unlocked word", 32'(idle_word), 32'h2A00);
        step(1);
        pins("R5 comp idle immediate", 4'b0111, 3'b111);
        step(3);
        pins("R4 main idle after dead-time", 4'b0000, 3'b111);
    endtask

    task automatic t_run;
        @(negedge clk) begin pwm_ref = 4'b0000; out_en = 1'b1; end
        step(1);
        pins("R6 run start", 4'b0000, 3'b111);
        @(negedge clk) pwm_ref = 4'b1111;
        step(1);
        pins("R6 R9 comp falls, ch3 rises", 4'b1000, 3'b000);
        step(2);
        pins("R7 main rise held", 4'b1000, 3'b000);
        step(1);
        pins("R7 main rise after D", 4'b1111, 3'b000);
        @(negedge clk) pwm_ref = 4'b0000;
        step(1);
        pins("R6 main falls", 4'b0000, 3'b000);
        step(2);
        pins("R8 comp rise held", 4'b0000, 3'b000);
        step(1);
        pins("R7 comp rise after D", 4'b0000, 3'b111);
        @(negedge clk) pwm_ref = 4'b0101;
        step(1);
        pins("R6 mixed pattern fall", 4'b0000, 3'b010);
        step(3);
        pins("R7 mixed pattern rise", 4'b0101, 3'b010);
    endtask

    task automatic t_idle_from_run;
        @(negedge clk) pwm_ref = 4'b1111;
        step(6);
        pins("R6 settled high", 4'b1111, 3'b000);
        @(negedge clk) out_en = 1'b0;
        step(1);
        pins("R5 R4 enable drop first edge", 4'b0111, 3'b111);
        step(2);
        pins("R4 main still held", 4'b0111, 3'b111);
        step(1);
        pins("R4 main idle reached", 4'b0000, 3'b111);
    endtask

    task automatic t_dt_zero;
        @(negedge clk) begin dead_time = 8'd0; pwm_ref = 4'b0000; out_en = 1'b1; end
        step(2);
        pins("R7 zero dt settle", 4'b0000, 3'b111);
        @(negedge clk) pwm_ref = 4'b0111;
        step(1);
        pins("R7 zero dt same edge", 4'b0111, 3'b000);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_lock();
        t_run();
        t_idle_from_run();
        t_dt_zero();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule